// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block controls one port of general-purpose pins, eight by default. Software reaches it through a small register bus. It keeps, for every pin, the direction, the output value, a digital input enable, an alternate-function select and pull-up and pull-down configuration bits. The data register sits behind a window of addresses. The word address inside that window is used as a bit mask, so a single bus access can read or change any chosen subset of the pins without touching the others.

Each pin has its own interrupt detector. The pin input first passes through a two-flop synchroniser. The detector then senses a rising edge, a falling edge, both edges, a high level or a low level. Edge events stay latched until software clears them by writing ones. Level status simply follows the pin. A per-pin mask decides which status bits reach the single combined interrupt line.

The pad side carries an output value and an output enable for each pin. These come either from the GPIO registers or from a peripheral, as the alternate-function select chooses. Pins in open-drain mode only ever drive low. The pull and input-enable bits are passed to the pads unchanged. A parameter picks the pins that leave reset in alternate-function mode, with input enabled and pull-up on. Either of the two reset inputs restores every register to that default.

Top module: `mgpio_port`

## Requirements
- R1: A write with address bits [11:10] = 00 is a data-register write. Address bits [9:2] form the mask, and only the data bits whose mask bit is 1 take the write data; the other bits keep their value.
- R2: A data-register read returns 0 for each bit whose mask bit (address [9:2]) is 0. A bit with mask 1 returns the data register bit when its direction bit is 1 (output), and the synchronised pin input when its direction bit is 0.
- R3: The bus state machine has two states. ST_IDLE moves to ST_RESP on a read request (bus_sel=1, bus_wr=0); otherwise it stays in ST_IDLE. ST_RESP moves back to ST_RESP on another read request and to ST_IDLE otherwise. bus_rvalid is 1 exactly in ST_RESP, and bus_rdata holds the read value from then until the next read.
- R4: After either reset (por_n or rst_n low), alternate-function select, digital enable and pull-up equal the ALT_PINS parameter (default 8'h0F). Every other register is 0, and the state machine is in ST_IDLE.
- R5: For a pin with alternate-function select 1, pad_out and pad_oe equal alt_out and alt_oe. Otherwise, with open-drain 0, they equal the data and direction bits. With open-drain 1, pad_out is 0 and pad_oe is direction AND NOT data.
- R6: In edge mode (sense bit 0), a pin's status bit latches on a rising edge when its both-edges bit is 0 and its polarity bit is 1. It latches on a falling edge when both-edges is 0 and polarity is 0, and on either edge when both-edges is 1. It stays set until a 1 is written to that bit of the clear register.
- R7: In level mode (sense bit 1), a pin's status bit is 1 while the synchronised pin is high (polarity 1) or low (polarity 0), and 0 otherwise.
- R8: A pin whose digital enable bit is 0 reads as 0 in the data register and produces no status bit in either mode.
- R9: The masked status register is the status bits ANDed with the interrupt mask, and irq is 1 exactly when any masked status bit is 1.
- R10: Configuration offsets (address bits [11:10] = 01, bits [1:0] = 00) are: 0x400 direction, 0x404 sense, 0x408 both-edges, 0x40C polarity, 0x410 interrupt mask, 0x414 status (read only), 0x418 masked status (read only), 0x41C clear (write only, reads 0), 0x420 alternate-function select, 0x424 open-drain, 0x428 pull-up, 0x42C pull-down, 0x430 digital enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | External reset, active low, asynchronous |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rvalid is 1 |
| bus_rvalid | output | 1 | Read response valid |
| pad_in | input | 8 | Pin input from pads |
| pad_out | output | 8 | Output value to pads |
| pad_oe | output | 8 | Output enable to pads |
| pad_pu | output | 8 | Pull-up enable to pads |
| pad_pd | output | 8 | Pull-down enable to pads |
| pad_ie | output | 8 | Digital input enable to pads |
| alt_out | input | 8 | Peripheral output value |
| alt_oe | input | 8 | Peripheral output enable |
| irq | output | 1 | Combined masked interrupt |

## Verification
Each result has its own latency. Read data and bus_rvalid appear one clock edge after the read request. Pad outputs follow the registers without delay, so they are correct straight after the write edge. Level status and pin reads trail a pin change by two edges (the synchroniser), and latched edge status by three. The bench drives inputs and samples outputs on falling edges. It reads the read response on the first falling edge after the request edge, and it waits four full cycles after every pin change before it reads status, so each check lands after its result is due.

// File: rtl/mgpio_pkg.sv
package mgpio_pkg;

    localparam int IDX_W = 8;

    // configuration word indices (byte offset = 0x400 + 4*index)
    localparam logic [IDX_W-1:0] IDX_DIR   = 8'd0;
    localparam logic [IDX_W-1:0] IDX_SENSE = 8'd1;
    localparam logic [IDX_W-1:0] IDX_BOTH  = 8'd2;
    localparam logic [IDX_W-1:0] IDX_POL   = 8'd3;
    localparam logic [IDX_W-1:0] IDX_MASK  = 8'd4;
    localparam logic [IDX_W-1:0] IDX_RAW   = 8'd5;
    localparam logic [IDX_W-1:0] IDX_MIS   = 8'd6;
    localparam logic [IDX_W-1:0] IDX_CLR   = 8'd7;
    localparam logic [IDX_W-1:0] IDX_AFSEL = 8'd8;
    localparam logic [IDX_W-1:0] IDX_ODR   = 8'd9;
    localparam logic [IDX_W-1:0] IDX_PU    = 8'd10;
    localparam logic [IDX_W-1:0] IDX_PD    = 8'd11;
    localparam logic [IDX_W-1:0] IDX_DEN   = 8'd12;

    localparam logic [1:0] BANK_DATA = 2'b00;
    localparam logic [1:0] BANK_CFG  = 2'b01;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

endpackage

// File: rtl/mgpio_pin_irq.sv
module mgpio_pin_irq (
    input  logic clk,
    input  logic rst_an,
    input  logic pad_in,
    input  logic den,
    input  logic sense,
    input  logic both,
    input  logic pol,
    input  logic clr,
    output logic pin_val,
    output logic raw
);
    logic sync1_q, sync2_q, prev_q, sticky_q;
    logic rise, fall, edge_hit, level_hit;

    always_ff @(posedge clk or negedge rst_an) begin
        if (!rst_an) begin
            sync1_q  <= 1'b0;
            sync2_q  <= 1'b0;
            prev_q   <= 1'b0;
            sticky_q <= 1'b0;
        end else begin
            sync1_q <= pad_in;
            sync2_q <= sync1_q;
            prev_q  <= pin_val;
            // a new event wins over a clear in the same cycle
            if (edge_hit && !sense)
                sticky_q <= 1'b1;
            else if (clr)
                sticky_q <= 1'b0;
        end
    end

    always_comb begin
        pin_val   = sync2_q & den;
        rise      = pin_val & ~prev_q;
        fall      = ~pin_val & prev_q;
        edge_hit  = both ? (rise | fall) : (pol ? rise : fall);
        level_hit = den & (pol ? sync2_q : ~sync2_q);
        raw       = sense ? level_hit : sticky_q;
    end

endmodule

// File: rtl/mgpio_regs.sv
module mgpio_regs
    import mgpio_pkg::*;
#(
    parameter int N_PINS = 8,
    parameter logic [N_PINS-1:0] ALT_PINS = 8'h0F
) (
    input  logic                clk,
    input  logic                rst_an,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [N_PINS+3:0]   bus_addr,
    input  logic [N_PINS-1:0]   bus_wdata,
    output logic [N_PINS-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic [N_PINS-1:0]   pin_val,
    input  logic [N_PINS-1:0]   raw_stat,
    output logic [N_PINS-1:0]   data_q,
    output logic [N_PINS-1:0]   dir_q,
    output logic [N_PINS-1:0]   sense_q,
    output logic [N_PINS-1:0]   both_q,
    output logic [N_PINS-1:0]   pol_q,
    output logic [N_PINS-1:0]   mask_q,
    output logic [N_PINS-1:0]   afsel_q,
    output logic [N_PINS-1:0]   odr_q,
    output logic [N_PINS-1:0]   pu_q,
    output logic [N_PINS-1:0]   pd_q,
    output logic [N_PINS-1:0]   den_q,
    output logic [N_PINS-1:0]   clr_pulse
);
    localparam int ADDR_W = N_PINS + 4;

    bus_state_e         state_q, state_d;
    logic [1:0]         bank;
    logic [N_PINS-1:0]  amask;
    logic [IDX_W-1:0]   cfg_idx;
    logic               data_hit, cfg_hit, rd_req, data_wr, cfg_wr;
    logic [N_PINS-1:0]  rd_val, rdata_q;

    always_comb begin
        bank     = bus_addr[ADDR_W-1:ADDR_W-2];
        amask    = bus_addr[N_PINS+1:2];
        cfg_idx  = IDX_W'(bus_addr[N_PINS+1:2]);
        data_hit = (bank == BANK_DATA);
        cfg_hit  = (bank == BANK_CFG) && (bus_addr[1:0] == 2'b00);
        rd_req   = bus_sel && !bus_wr;
        data_wr  = bus_sel && bus_wr && data_hit;
        cfg_wr   = bus_sel && bus_wr && cfg_hit;
        clr_pulse = (cfg_wr && cfg_idx == IDX_CLR) ? bus_wdata : '0;
    end

    // register file
    always_ff @(posedge clk or negedge rst_an) begin
        if (!rst_an) begin
            data_q  <= '0;
            dir_q   <= '0;
            sense_q <= '0;
            both_q  <= '0;
            pol_q   <= '0;
            mask_q  <= '0;
            odr_q   <= '0;
            pd_q    <= '0;
            afsel_q <= ALT_PINS;
            pu_q    <= ALT_PINS;
            den_q   <= ALT_PINS;
        end else begin
            if (data_wr)
                data_q <= (data_q & ~amask) | (bus_wdata & amask);
            if (cfg_wr) begin
                unique case (cfg_idx)
                    IDX_DIR:   dir_q   <= bus_wdata;
                    IDX_SENSE: sense_q <= bus_wdata;
                    IDX_BOTH:  both_q  <= bus_wdata;
                    IDX_POL:   pol_q   <= bus_wdata;
                    IDX_MASK:  mask_q  <= bus_wdata;
                    IDX_AFSEL: afsel_q <= bus_wdata;
                    IDX_ODR:   odr_q   <= bus_wdata;
                    IDX_PU:    pu_q    <= bus_wdata;
                    IDX_PD:    pd_q    <= bus_wdata;
                    IDX_DEN:   den_q   <= bus_wdata;
                    default:   ;
                endcase
            end
        end
    end

    // read value selection
    always_comb begin
        rd_val = '0;
        if (data_hit) begin
            rd_val = ((dir_q & data_q) | (~dir_q & pin_val)) & amask;
        end else if (cfg_hit) begin
            unique case (cfg_idx)
                IDX_DIR:   rd_val = dir_q;
                IDX_SENSE: rd_val = sense_q;
                IDX_BOTH:  rd_val = both_q;
                IDX_POL:   rd_val = pol_q;
                IDX_MASK:  rd_val = mask_q;
                IDX_RAW:   rd_val = raw_stat;
                IDX_MIS:   rd_val = raw_stat & mask_q;
                IDX_AFSEL: rd_val = afsel_q;
                IDX_ODR:   rd_val = odr_q;
                IDX_PU:    rd_val = pu_q;
                IDX_PD:    rd_val = pd_q;
                IDX_DEN:   rd_val = den_q;
                default:   rd_val = '0;
            endcase
        end
    end

    // bus response state machine: state register
    always_ff @(posedge clk or negedge rst_an) begin
        if (!rst_an) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req)
                rdata_q <= rd_val;
        end
    end

    // next state
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_rvalid = (state_q == ST_RESP);
        bus_rdata  = rdata_q;
    end

endmodule

// File: rtl/mgpio_pad_mux.sv
module mgpio_pad_mux #(
    parameter int N_PINS = 8
) (
    input  logic [N_PINS-1:0] afsel,
    input  logic [N_PINS-1:0] odr,
    input  logic [N_PINS-1:0] dir,
    input  logic [N_PINS-1:0] data,
    input  logic [N_PINS-1:0] alt_out,
    input  logic [N_PINS-1:0] alt_oe,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe
);
    for (genvar p = 0; p < N_PINS; p++) begin : g_bit
        always_comb begin
            if (afsel[p]) begin
                pad_out[p] = alt_out[p];
                pad_oe[p]  = alt_oe[p];
            end else if (odr[p]) begin
                pad_out[p] = 1'b0;
                pad_oe[p]  = dir[p] & ~data[p];
            end else begin
                pad_out[p] = data[p];
                pad_oe[p]  = dir[p];
            end
        end
    end

endmodule

// File: rtl/mgpio_port.sv
module mgpio_port #(
    parameter int N_PINS = 8,
    parameter logic [N_PINS-1:0] ALT_PINS = 8'h0F
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [N_PINS+3:0] bus_addr,
    input  logic [N_PINS-1:0] bus_wdata,
    output logic [N_PINS-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_out,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_pu,
    output logic [N_PINS-1:0] pad_pd,
    output logic [N_PINS-1:0] pad_ie,
    input  logic [N_PINS-1:0] alt_out,
    input  logic [N_PINS-1:0] alt_oe,
    output logic              irq
);
    logic              rst_an;
    logic [N_PINS-1:0] data_q, dir_q, sense_q, both_q, pol_q, mask_q;
    logic [N_PINS-1:0] afsel_q, odr_q, pu_q, pd_q, den_q;
    logic [N_PINS-1:0] clr_pulse, pin_val, raw_stat;

    assign rst_an = por_n & rst_n;

    mgpio_regs #(.N_PINS(N_PINS), .ALT_PINS(ALT_PINS)) u_regs (
        .clk(clk), .rst_an(rst_an),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pin_val(pin_val), .raw_stat(raw_stat),
        .data_q(data_q), .dir_q(dir_q), .sense_q(sense_q), .both_q(both_q),
        .pol_q(pol_q), .mask_q(mask_q), .afsel_q(afsel_q), .odr_q(odr_q),
        .pu_q(pu_q), .pd_q(pd_q), .den_q(den_q), .clr_pulse(clr_pulse)
    );

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        mgpio_pin_irq u_pin (
            .clk(clk), .rst_an(rst_an), .pad_in(pad_in[p]),
            .den(den_q[p]), .sense(sense_q[p]), .both(both_q[p]),
            .pol(pol_q[p]), .clr(clr_pulse[p]),
            .pin_val(pin_val[p]), .raw(raw_stat[p])
        );
    end

    mgpio_pad_mux #(.N_PINS(N_PINS)) u_mux (
        .afsel(afsel_q), .odr(odr_q), .dir(dir_q), .data(data_q),
        .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    assign pad_pu = pu_q;
    assign pad_pd = pd_q;
    assign pad_ie = den_q;
    assign irq    = |(raw_stat & mask_q);

endmodule

// File: rtl/mgpio_port_chk.sv
module mgpio_port_chk #(
    parameter int N_PINS = 8
) (
    input logic              clk,
    input logic              rst_an,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [N_PINS+3:0] bus_addr,
    input logic [N_PINS-1:0] bus_rdata,
    input logic              bus_rvalid,
    input logic [N_PINS-1:0] data_q,
    input logic [N_PINS-1:0] mask_q,
    input logic [N_PINS-1:0] den_q,
    input logic [N_PINS-1:0] sense_q,
    input logic [N_PINS-1:0] raw_stat,
    input logic              irq
);
    localparam int ADDR_W = N_PINS + 4;

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_an)
        (bus_sel && !bus_wr) |=> bus_rvalid); // R3

    AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_an)
        !(bus_sel && !bus_wr) |=> !bus_rvalid); // R3

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_an)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R3

    AST_MASKED_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_an)
        (bus_sel && bus_wr && bus_addr[ADDR_W-1:ADDR_W-2] == 2'b00)
        |=> ((data_q & ~$past(bus_addr[N_PINS+1:2]))
             == ($past(data_q) & ~$past(bus_addr[N_PINS+1:2])))); // R1

    AST_NO_IRQ_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_an)
        (mask_q == '0) |-> !irq); // R9

    AST_LEVEL_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_an)
        (raw_stat & sense_q & ~den_q) == '0); // R8

endmodule

bind mgpio_port mgpio_port_chk #(.N_PINS(N_PINS)) u_chk (
    .clk(clk), .rst_an(rst_an), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .data_q(data_q), .mask_q(mask_q), .den_q(den_q), .sense_q(sense_q),
    .raw_stat(raw_stat), .irq(irq)
);

// File: tb/mgpio_port_tb.sv
`timescale 1ns/1ps
module mgpio_port_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       bus_rvalid, irq;
    logic [7:0] pad_in = '0, pad_out, pad_oe, pad_pu, pad_pd, pad_ie;
    logic [7:0] alt_out = '0, alt_oe = '0;

    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mgpio_port dut_i (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pu(pad_pu), .pad_pd(pad_pd), .pad_ie(pad_ie),
        .alt_out(alt_out), .alt_oe(alt_oe), .irq(irq)
    );

    // {write, address, write data, expected read data}
    localparam int NVEC = 15;
    localparam logic [28:0] VEC [0:NVEC-1] = '{
        {1'b0, 12'h420, 8'h00, 8'h0F},
        {1'b0, 12'h430, 8'h00, 8'h0F},
        {1'b0, 12'h428, 8'h00, 8'h0F},
        {1'b0, 12'h42C, 8'h00, 8'h00},
        {1'b0, 12'h400, 8'h00, 8'h00},
        {1'b1, 12'h400, 8'hFF, 8'h00},
        {1'b1, 12'h3FC, 8'hA5, 8'h00},
        {1'b0, 12'h3FC, 8'h00, 8'hA5},
        {1'b1, 12'h03C, 8'h5A, 8'h00},
        {1'b0, 12'h3FC, 8'h00, 8'hAA},
        {1'b0, 12'h3C0, 8'h00, 8'hA0},
        {1'b1, 12'h000, 8'hFF, 8'h00},
        {1'b0, 12'h3FC, 8'h00, 8'hAA},
        {1'b0, 12'h008, 8'h00, 8'h02},
        {1'b0, 12'h004, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        chk("R3 rvalid", {7'd0, bus_rvalid}, 8'h01);
        bus_sel = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [11:0] a, input logic [7:0] exp);
        logic [7:0] d;
        rd(a, d);
        chk(tag, d, exp);
    endtask

    task automatic settle;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);
        chk("R4 rvalid at reset", {7'd0, bus_rvalid}, 8'h00);
        chk("R4 pad_pu at reset", pad_pu, 8'h0F);
        chk("R4 pad_ie at reset", pad_ie, 8'h0F);
        chk("R4 pad_oe at reset", pad_oe, 8'h00);

        // vector table: reset values (R4), masked data access (R1, R2)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][28]) begin
                wr(VEC[i][27:16], VEC[i][15:8]);
            end else begin
                rd(VEC[i][27:16], d);
                chk((i < 5) ? "R4 table read" : "R1/R2 table read", d, VEC[i][7:0]);
            end
        end
        @(negedge clk);
        chk("R3 rvalid drops after read", {7'd0, bus_rvalid}, 8'h00);

        // R5 pad multiplexer: data AA, dir FF, afsel 0F, alt all 0
        chk("R5 pad_oe alt low pins", pad_oe, 8'hF0);
        chk("R5 pad_out alt low pins", pad_out, 8'hA0);
        wr(12'h420, 8'h00);
        chk("R5 pad_oe gpio", pad_oe, 8'hFF);
        chk("R5 pad_out gpio", pad_out, 8'hAA);
        wr(12'h424, 8'hFF);
        chk("R5 pad_out open drain", pad_out, 8'h00);
        chk("R5 pad_oe open drain", pad_oe, 8'h55);
        wr(12'h424, 8'h00);
        wr(12'h400, 8'h00);
        wr(12'h430, 8'hFF);
        alt_out = 8'h03; alt_oe = 8'h01;
        wr(12'h420, 8'h03);
        chk("R5 pad_oe mixed", pad_oe, 8'h01);
        chk("R5 pad_out mixed", pad_out, 8'hAB);
        wr(12'h420, 8'h00);
        alt_out = 8'h00; alt_oe = 8'h00;
        rd_chk("R10 clear reads zero", 12'h41C, 8'h00);

        // R2 input read
        pad_in = 8'h3C; settle();
        rd_chk("R2 input full mask", 12'h3FC, 8'h3C);
        rd_chk("R2 input partial mask", 12'h030, 8'h0C);

        // R6 edges
        pad_in = 8'h00; settle();
        wr(12'h410, 8'hFF);
        wr(12'h40C, 8'hFF);
        wr(12'h41C, 8'hFF);
        rd_chk("R6 status clear", 12'h414, 8'h00);
        pad_in = 8'h01; settle();
        rd_chk("R6 rising latched", 12'h414, 8'h01);
        chk("R9 irq on rising", {7'd0, irq}, 8'h01);
        pad_in = 8'h00; settle();
        rd_chk("R6 sticky after fall", 12'h414, 8'h01);
        wr(12'h41C, 8'h01);
        rd_chk("R6 write one clears", 12'h414, 8'h00);
        chk("R9 irq after clear", {7'd0, irq}, 8'h00);
        wr(12'h40C, 8'h00);
        pad_in = 8'h02; settle();
        rd_chk("R6 falling ignores rise", 12'h414, 8'h00);
        pad_in = 8'h00; settle();
        rd_chk("R6 falling latched", 12'h414, 8'h02);
        wr(12'h41C, 8'hFF);
        wr(12'h408, 8'hFF);
        pad_in = 8'h04; settle();
        rd_chk("R6 both rise", 12'h414, 8'h04);
        wr(12'h41C, 8'h04);
        pad_in = 8'h00; settle();
        rd_chk("R6 both fall", 12'h414, 8'h04);
        wr(12'h41C, 8'hFF);
        wr(12'h408, 8'h00);

        // R7 levels, R9 mask
        wr(12'h404, 8'hFF);
        wr(12'h40C, 8'hFF);
        pad_in = 8'h10; settle();
        rd_chk("R7 high level", 12'h414, 8'h10);
        chk("R9 irq high level", {7'd0, irq}, 8'h01);
        wr(12'h40C, 8'h00);
        rd_chk("R7 low level", 12'h414, 8'hEF);
        wr(12'h410, 8'h10);
        rd_chk("R9 masked status none", 12'h418, 8'h00);
        chk("R9 irq masked off", {7'd0, irq}, 8'h00);
        wr(12'h40C, 8'hFF);
        rd_chk("R9 masked status one", 12'h418, 8'h10);
        chk("R9 irq masked on", {7'd0, irq}, 8'h01);
        wr(12'h410, 8'h0F);
        chk("R9 irq other mask", {7'd0, irq}, 8'h00);

        // R8 digital enable off
        wr(12'h410, 8'hFF);
        wr(12'h430, 8'h00);
        rd_chk("R8 level status off", 12'h414, 8'h00);
        chk("R8 irq off", {7'd0, irq}, 8'h00);
        rd_chk("R8 input reads zero", 12'h3FC, 8'h00);
        wr(12'h404, 8'h00);
        wr(12'h41C, 8'hFF);
        pad_in = 8'h20; settle();
        rd_chk("R8 edge status off", 12'h414, 8'h00);

        // R4 both resets
        wr(12'h400, 8'h5A);
        wr(12'h428, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R4 dir after rst_n", 12'h400, 8'h00);
        rd_chk("R4 afsel after rst_n", 12'h420, 8'h0F);
        rd_chk("R4 pull-up after rst_n", 12'h428, 8'h0F);
        wr(12'h428, 8'h00);
        wr(12'h430, 8'hF0);
        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        rd_chk("R4 pull-up after por_n", 12'h428, 8'h0F);
        rd_chk("R4 enable after por_n", 12'h430, 8'h0F);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule